// File: doc/BRIEF.md
# Flash Slot Rewrite Sequencer

This block rewrites one fixed-size slot of a serial NOR flash with a new image, with no processor involved. A start pulse carries the slot number. The block then makes two passes over the slot in chunk-sized steps. The first pass reads each chunk and erases only where the chunk is not blank. Each erase is confirmed by reading the chunk again. The second pass pulls image data one chunk at a time from a source port. It programs each chunk as two half-chunk pages, then reads the chunk back to compare it, and allows one targeted retry.

The flash is reached through an abstract, one-command-at-a-time port. The block issues a command with a one-cycle request and the flash answers with an acknowledge. The wire protocol and the erase sector size stay outside the block. Since the sector size is unknown, erasing is driven purely by address: an erase at a chunk address may clear more than that chunk, and later chunks that are already blank are then skipped. A coarse progress count follows each pass.

Top module: `flash_slot_writer`

## Requirements
- R1: The slot base address is the slot number times SLOT_BYTES, and every pass walks the slot at addresses base + k·CHUNK_BYTES for rising k. Bytes outside the selected slot are never changed.
- R2: In the erase pass, each chunk is read (op 0). An erase (op 2) at the chunk address is issued only when at least one byte read differs from 0xFF. A blank slot therefore sees no erase.
- R3: After an erase, the status register (op 4) is polled until bit 0 reads 0, and the chunk is then read again. If any byte is still not 0xFF, the block stops with err=1, err_addr = chunk address + index of the first such byte, err_exp = 0xFF and err_act = that byte.
- R4: Each erase and each page program is directly preceded by a write-enable command (op 1).
- R5: Each source chunk is written as two page programs (op 3) of CHUNK_BYTES/2 bytes each. The first goes at the chunk address, the second at the chunk address plus CHUNK_BYTES/2.
- R6: After both pages, the chunk is read back and compared with the source bytes. On the first mismatch, only the page holding the first mismatching index is programmed again (index below CHUNK_BYTES/2 selects the lower page), and the chunk is verified again.
- R7: A mismatch in the second verify stops the block with err=1. In that case err_addr = chunk address + first mismatching index, err_exp = the source byte and err_act = the byte read back.
- R8: A source chunk that ends (src_end) with no bytes ends the program pass: done=1, and the rest of the slot is left erased.
- R9: Per completed chunk, an accumulator gains CHUNK_BYTES. When it then exceeds SLOT_BYTES/STEPS, it loses that amount and progress rises by one. Progress restarts at zero when the first source transfer of the program pass begins.
- R10: After every erase or program, no further write-enable is issued until a status read shows bit 0 clear.
- R11: After reset, busy, done, err and progress are 0. While busy, start is ignored. done and err are never both high, and neither is high while busy.
- R12: At most one flash command is outstanding: a request is never followed by another request before the acknowledge, and no flash request is made while source data is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin rewrite of slot `slot` |
| slot | input | SLOT_W | Slot number |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last operation finished cleanly |
| err | output | 1 | Last operation stopped on an error |
| err_addr | output | ADDR_W | Address of failing byte |
| err_exp | output | 8 | Expected byte at failure |
| err_act | output | 8 | Byte read at failure |
| progress | output | 8 | Progress steps in current pass |
| fl_req | output | 1 | One-cycle command request |
| fl_op | output | 3 | 0 read chunk, 1 write enable, 2 erase, 3 program page, 4 read status |
| fl_addr | output | ADDR_W | Command address |
| fl_ack | input | 1 | Command complete; status byte valid on fl_rd_data with it |
| fl_rd_valid | input | 1 | Read byte valid |
| fl_rd_data | input | 8 | Read byte or status byte |
| fl_wr_take | input | 1 | Flash consumes fl_wr_data this cycle |
| fl_wr_data | output | 8 | Page byte to program |
| src_req | output | 1 | Next source chunk wanted |
| src_valid | input | 1 | Source byte valid |
| src_data | input | 8 | Source byte |
| src_end | input | 1 | Source chunk complete |

## Verification
The bench builds the block with 2 slot bits, 16-bit addresses, a 2048-byte slot and 16-byte chunks, so a whole slot is 128 chunks and a full two-pass rewrite of every slot fits in a short run. The flash model erases 64-byte sectors. That puts several chunks in one sector and exercises the skip-after-erase path, and with only four slots every slot can be hit and the untouched neighbours compared byte for byte. Faults injected into the model (a byte that never erases, and a byte that fails to program once or always) bring both error exits and the single-half retry within reach.

// File: rtl/flash_slot_writer.sv
module flash_slot_writer #(
  parameter int SLOT_W      = 3,
  parameter int ADDR_W      = 32,
  parameter int SLOT_BYTES  = 4194304,
  parameter int CHUNK_BYTES = 512,
  parameter int STEPS       = 160
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SLOT_W-1:0] slot,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [ADDR_W-1:0] err_addr,
  output logic [7:0]        err_exp,
  output logic [7:0]        err_act,
  output logic [7:0]        progress,
  output logic              fl_req,
  output logic [2:0]        fl_op,
  output logic [ADDR_W-1:0] fl_addr,
  input  logic              fl_ack,
  input  logic              fl_rd_valid,
  input  logic [7:0]        fl_rd_data,
  input  logic              fl_wr_take,
  output logic [7:0]        fl_wr_data,
  output logic              src_req,
  input  logic              src_valid,
  input  logic [7:0]        src_data,
  input  logic              src_end
);
  localparam int PAGE = CHUNK_BYTES / 2;
  localparam int CW   = $clog2(CHUNK_BYTES);
  localparam int PW   = CW - 1;
  localparam int SCW  = CW + 1;
  localparam int NCH  = SLOT_BYTES / CHUNK_BYTES;
  localparam int OW   = $clog2(NCH);
  localparam int SB   = $clog2(SLOT_BYTES);
  localparam int STEP = SLOT_BYTES / STEPS;

  typedef enum logic [3:0] {IDLE, E_RD, E_WEN, E_ERS, E_POL, E_CHK,
                            P_SRC, P_WEN, P_PRG, P_POL, P_VER} st_t;
  st_t st;

  logic [7:0]        data_q [CHUNK_BYTES];
  logic [SLOT_W-1:0] slot_q;
  logic [OW-1:0]     off;
  logic [SCW-1:0]    scnt;
  logic [CW-1:0]     rptr, bad_idx;
  logic [PW-1:0]     wptr;
  logic              sent, half, retry, bad, pfirst;
  logic [7:0]        bad_val, bad_exp;
  logic [31:0]       acc;

  wire [ADDR_W-1:0] base  = ADDR_W'(slot_q) << SB;
  wire [ADDR_W-1:0] caddr = base + (ADDR_W'(off) << CW);
  wire [7:0]        cmp   = (st == P_VER) ? data_q[rptr] : 8'hFF;
  wire              last  = (off == OW'(NCH - 1));
  wire [31:0]       acc_n = acc + 32'(CHUNK_BYTES);
  wire              wip   = fl_rd_data[0];
  wire chunk_ok = fl_ack && !bad && (st == E_RD || st == E_CHK || st == P_VER);
  wire fail     = fl_ack && bad && (st == E_CHK || (st == P_VER && retry));

  assign busy       = (st != IDLE);
  assign src_req    = (st == P_SRC);
  assign fl_req     = busy && !src_req && !sent;
  assign fl_addr    = caddr + ((st == P_PRG && half) ? ADDR_W'(PAGE) : '0);
  assign fl_wr_data = data_q[{half, wptr}];

  always_comb
    case (st)
      E_RD, E_CHK, P_VER: fl_op = 3'd0;
      E_WEN, P_WEN:       fl_op = 3'd1;
      E_ERS:              fl_op = 3'd2;
      P_PRG:              fl_op = 3'd3;
      default:            fl_op = 3'd4;
    endcase

  always_ff @(posedge clk)
    if (st == P_SRC && src_valid) data_q[scnt[CW-1:0]] <= src_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= IDLE; slot_q <= '0; off <= '0; scnt <= '0; rptr <= '0; wptr <= '0;
      sent <= 1'b0; half <= 1'b0; retry <= 1'b0; bad <= 1'b0; pfirst <= 1'b0;
      bad_idx <= '0; bad_val <= '0; bad_exp <= '0; acc <= '0; progress <= '0;
      done <= 1'b0; err <= 1'b0; err_addr <= '0; err_exp <= '0; err_act <= '0;
    end else begin
      if (fl_ack) sent <= 1'b0;
      else if (fl_req) sent <= 1'b1;
      if (fl_req) begin
        rptr <= '0; wptr <= '0; bad <= 1'b0;
      end
      if (fl_rd_valid) begin
        rptr <= rptr + CW'(1);
        if (!bad && fl_rd_data != cmp) begin
          bad <= 1'b1; bad_idx <= rptr; bad_val <= fl_rd_data; bad_exp <= cmp;
        end
      end
      if (fl_wr_take) wptr <= wptr + PW'(1);

      if (chunk_ok) begin
        off <= last ? '0 : off + OW'(1);
        if (acc_n > 32'(STEP)) begin
          acc <= acc_n - 32'(STEP); progress <= progress + 8'd1;
        end else acc <= acc_n;
      end
      if (fail) begin
        err <= 1'b1; err_addr <= caddr + ADDR_W'(bad_idx);
        err_exp <= bad_exp; err_act <= bad_val; st <= IDLE;
      end

      case (st)
        IDLE: if (start) begin
          slot_q <= slot; off <= '0; acc <= '0; progress <= '0;
          done <= 1'b0; err <= 1'b0; st <= E_RD;
        end
        E_RD:  if (fl_ack) st <= bad ? E_WEN : (last ? P_SRC : E_RD);
        E_WEN: if (fl_ack) st <= E_ERS;
        E_ERS: if (fl_ack) st <= E_POL;
        E_POL: if (fl_ack && !wip) st <= E_CHK;
        E_CHK: if (chunk_ok) st <= last ? P_SRC : E_RD;
        P_SRC: begin
          if (pfirst && (src_valid || src_end)) begin
            pfirst <= 1'b0; acc <= '0; progress <= '0;
          end
          if (src_valid) scnt <= scnt + SCW'(1);
          if (src_end) begin
            scnt <= '0;
            if (scnt == '0) begin done <= 1'b1; st <= IDLE; end
            else begin half <= 1'b0; retry <= 1'b0; st <= P_WEN; end
          end
        end
        P_WEN: if (fl_ack) st <= P_PRG;
        P_PRG: if (fl_ack) st <= P_POL;
        P_POL: if (fl_ack && !wip) begin
          if (retry || half) st <= P_VER;
          else begin half <= 1'b1; st <= P_WEN; end
        end
        P_VER: if (fl_ack) begin
          if (!bad) begin
            if (last) begin done <= 1'b1; st <= IDLE; end
            else st <= P_SRC;
          end else if (!retry) begin
            retry <= 1'b1; half <= bad_idx[CW-1]; st <= P_WEN;
          end
        end
        default: st <= IDLE;
      endcase

      if ((st == E_RD || st == E_CHK) && chunk_ok && last) pfirst <= 1'b1;
    end
endmodule

// File: rtl/flash_slot_writer_chk.sv
module flash_slot_writer_chk #(
  parameter int STEPS = 160
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic [7:0] progress,
  input logic       fl_req,
  input logic [2:0] fl_op,
  input logic       fl_ack,
  input logic       fl_wip,
  input logic       src_req
);
  logic [2:0] last_op;
  logic       pend;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      last_op <= 3'd0; pend <= 1'b0;
    end else begin
      if (fl_req) last_op <= fl_op;
      if (fl_req && (fl_op == 3'd2 || fl_op == 3'd3)) pend <= 1'b1;
      else if (fl_ack && last_op == 3'd4 && !fl_wip) pend <= 1'b0;
    end

  AST_WREN_BEFORE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req && (fl_op == 3'd2 || fl_op == 3'd3) |-> last_op == 3'd1); // R4
  AST_NO_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req && fl_op == 3'd1 |-> !pend); // R10
  AST_SINGLE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req |=> !fl_req); // R12
  AST_SOURCE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    src_req |-> !fl_req); // R12
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err)); // R11
  AST_BUSY_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done && !err); // R11
  AST_PROGRESS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    progress <= 8'(STEPS)); // R9
endmodule

bind flash_slot_writer flash_slot_writer_chk #(.STEPS(STEPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .progress(progress), .fl_req(fl_req), .fl_op(fl_op), .fl_ack(fl_ack),
  .fl_wip(fl_rd_data[0]), .src_req(src_req));

// File: tb/sim_flash_slot_writer.sv
`timescale 1ns/1ps
module sim_flash_slot_writer;
  localparam int SLB = 2048, CH = 16, PG = 8, SEC = 64, MEMB = 8192, STEP = 2048 / 160;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] slot = '0;
  logic busy, done, err, fl_req, fl_ack = 1'b0, fl_rd_valid = 1'b0, fl_wr_take = 1'b0;
  logic src_req, src_valid = 1'b0, src_end = 1'b0;
  logic [15:0] err_addr, fl_addr;
  logic [7:0] err_exp, err_act, progress, fl_rd_data = '0, fl_wr_data, src_data = '0;
  logic [2:0] fl_op;

  always #2.5 clk = ~clk;

  flash_slot_writer #(.SLOT_W(2), .ADDR_W(16), .SLOT_BYTES(SLB), .CHUNK_BYTES(CH), .STEPS(160)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .slot(slot), .busy(busy), .done(done), .err(err),
    .err_addr(err_addr), .err_exp(err_exp), .err_act(err_act), .progress(progress),
    .fl_req(fl_req), .fl_op(fl_op), .fl_addr(fl_addr), .fl_ack(fl_ack), .fl_rd_valid(fl_rd_valid),
    .fl_rd_data(fl_rd_data), .fl_wr_take(fl_wr_take), .fl_wr_data(fl_wr_data),
    .src_req(src_req), .src_valid(src_valid), .src_data(src_data), .src_end(src_end));

  logic [7:0] fmem [MEMB];
  logic [7:0] snap [MEMB];
  int n_tests = 0, n_fail = 0;
  int mst = 0, maddr = 0, mcnt = 0, busy_cnt = 0, wel = 0, a = 0;
  int n_erase = 0, n_prog = 0, n_vbusy = 0, n_vwel = 0, n_ovl = 0, n_pfpage = 0;
  int stuck_addr = -1, pf_addr = -1, pf_mode = 0, pf_done = 0;
  int src_total = 0, src_sent = 0, src_slot = 0, sst = 0, scnt = 0, cap_done = 0, e_prog = 0;

  function automatic logic [7:0] img(int s, int i);
    return 8'(i * 37 + s * 5 + 11);
  endfunction
  function automatic logic [7:0] pre(int ad);
    return ((ad / SEC) % 2 == 0) ? 8'(ad * 13 + 7) : 8'hFF;
  endfunction
  function automatic int prog_exp(int n);
    int acc = 0, p = 0;
    for (int k = 0; k < n; k++) begin
      acc += CH;
      if (acc > STEP) begin acc -= STEP; p++; end
    end
    return p;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // flash model
  always @(posedge clk) begin
    fl_ack <= 1'b0; fl_rd_valid <= 1'b0;
    if (fl_req && mst != 0) n_ovl++;
    if (mst == 0) begin
      if (fl_req) begin
        maddr = int'(fl_addr); mcnt = 0;
        case (fl_op)
          3'd0: mst = 1;
          3'd1: begin if (busy_cnt > 0) n_vbusy++; wel = 1; fl_ack <= 1'b1; end
          3'd2: begin
            if (busy_cnt > 0) n_vbusy++;
            if (wel == 0) n_vwel++;
            wel = 0; n_erase++; busy_cnt = 3;
            for (int i = 0; i < SEC; i++) begin
              a = (maddr / SEC) * SEC + i;
              if (a != stuck_addr) fmem[a] = 8'hFF;
            end
            fl_ack <= 1'b1;
          end
          3'd3: begin
            if (busy_cnt > 0) n_vbusy++;
            if (wel == 0) n_vwel++;
            wel = 0; n_prog++;
            if (pf_addr >= 0 && pf_addr / PG == maddr / PG) n_pfpage++;
            fl_wr_take <= 1'b1; mst = 2;
          end
          default: begin
            fl_rd_data <= {7'd0, busy_cnt > 0};
            if (busy_cnt > 0) busy_cnt--;
            fl_ack <= 1'b1;
          end
        endcase
      end
    end else if (mst == 1) begin
      if (mcnt < CH) begin
        fl_rd_valid <= 1'b1; fl_rd_data <= fmem[maddr + mcnt]; mcnt++;
      end else begin
        fl_ack <= 1'b1; mst = 0;
      end
    end else begin
      a = maddr + mcnt;
      if (a == pf_addr && (pf_mode == 2 || (pf_mode == 1 && pf_done == 0))) pf_done = 1;
      else fmem[a] = fmem[a] & fl_wr_data;
      mcnt++;
      if (mcnt == PG) begin
        fl_wr_take <= 1'b0; fl_ack <= 1'b1; busy_cnt = 3; mst = 0;
      end
    end
  end

  // source model
  always @(posedge clk) begin
    src_end <= 1'b0; src_valid <= 1'b0;
    if (src_req && cap_done == 0) begin e_prog = int'(progress); cap_done = 1; end
    case (sst)
      0: if (src_req) begin
        if (src_sent < src_total) begin sst = 1; scnt = 0; end
        else begin src_end <= 1'b1; sst = 2; end
      end
      1: begin
        src_valid <= 1'b1; src_data <= img(src_slot, src_sent * CH + scnt); scnt++;
        if (scnt == CH) sst = 3;
      end
      3: begin src_end <= 1'b1; src_sent++; sst = 2; end
      default: if (!src_req) sst = 0;
    endcase
  end

  task automatic fill(int blank_slot);
    for (int i = 0; i < MEMB; i++) fmem[i] = (i / SLB == blank_slot) ? 8'hFF : pre(i);
  endtask

  task automatic run(int s, int n, bit poke);
    for (int i = 0; i < MEMB; i++) snap[i] = fmem[i];
    src_total = n; src_sent = 0; src_slot = s; cap_done = 0; pf_done = 0;
    n_erase = 0; n_prog = 0; n_vbusy = 0; n_vwel = 0; n_ovl = 0; n_pfpage = 0;
    @(negedge clk) slot = 2'(s); start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (poke) begin
      repeat (10) @(negedge clk);
      slot = 2'(s ^ 1); start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    while (busy) @(negedge clk);
  endtask

  function automatic int dirty_sectors(int s);
    int c = 0;
    for (int k = 0; k < SLB / SEC; k++) begin
      bit d = 0;
      for (int i = 0; i < SEC; i++) if (snap[s * SLB + k * SEC + i] != 8'hFF) d = 1;
      if (d) c++;
    end
    return c;
  endfunction

  task automatic check_slot(int s, int n, string tag);
    int bad = 0, other = 0;
    for (int i = 0; i < MEMB; i++) begin
      if (i / SLB == s) begin
        if (fmem[i] != (((i % SLB) < n * CH) ? img(s, i % SLB) : 8'hFF)) bad++;
      end else if (fmem[i] != snap[i]) other++;
    end
    chk(bad == 0, {tag, " R1 slot content"}, bad, 0);
    chk(other == 0, {tag, " R1 other slots untouched"}, other, 0);
  endtask

  task automatic check_clean(string tag);
    chk(n_vwel == 0, {tag, " R4 write without enable"}, n_vwel, 0);
    chk(n_vbusy == 0, {tag, " R10 write while busy"}, n_vbusy, 0);
    chk(n_ovl == 0, {tag, " R12 overlapping command"}, n_ovl, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL R11 watchdog act=running exp=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int ex;
    fill(-1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !err, "R11 reset flags", {busy, done, err}, 0);
    chk(progress == 0 && !fl_req && !src_req, "R11 reset outputs", progress, 0);

    // T1: slot 1, half-dirty sectors, full image
    run(1, 128, 0);
    ex = dirty_sectors(1);
    chk(done && !err, "T1 R11 done", {done, err}, 2);
    check_slot(1, 128, "T1");
    chk(n_erase == ex, "T1 R2 erase count", n_erase, ex);
    chk(n_prog == 256, "T1 R5 page programs", n_prog, 256);
    chk(e_prog == prog_exp(128), "T1 R9 erase-pass progress", e_prog, prog_exp(128));
    chk(progress == prog_exp(128), "T1 R9 program-pass progress", progress, prog_exp(128));
    check_clean("T1");

    // T2: blank slot 2, short image, start pulse while busy
    fill(2);
    run(2, 5, 1);
    chk(done && !err, "T2 R8 done on empty chunk", {done, err}, 2);
    check_slot(2, 5, "T2");
    chk(n_erase == 0, "T2 R2 blank slot no erase", n_erase, 0);
    chk(n_prog == 10, "T2 R5 page programs", n_prog, 10);
    chk(progress == prog_exp(5), "T2 R9 progress", progress, prog_exp(5));
    chk(fmem[3 * SLB + 5] == pre(3 * SLB + 5), "T2 R11 start ignored while busy", fmem[3 * SLB + 5], pre(3 * SLB + 5));
    check_clean("T2");

    // T3: slot 0, one byte fails to program once (upper page)
    fill(-1);
    pf_addr = 3 * CH + 10; pf_mode = 1;
    run(0, 128, 0);
    chk(done && !err, "T3 R6 retry recovers", {done, err}, 2);
    check_slot(0, 128, "T3");
    chk(n_prog == 257, "T3 R6 one extra program", n_prog, 257);
    chk(n_pfpage == 2, "T3 R6 retry on failing half", n_pfpage, 2);
    check_clean("T3");

    // T4: slot 3, byte never programs (lower page)
    fill(-1);
    pf_addr = 3 * SLB + 20 * CH + 2; pf_mode = 2;
    run(3, 128, 0);
    chk(err && !done, "T4 R7 error raised", {done, err}, 1);
    chk(err_addr == 16'(pf_addr), "T4 R7 error address", err_addr, pf_addr);
    chk(err_exp == img(3, 20 * CH + 2), "T4 R7 expected byte", err_exp, img(3, 20 * CH + 2));
    chk(err_act == 8'hFF, "T4 R7 actual byte", err_act, 8'hFF);
    chk(n_prog == 43, "T4 R7 halts after retry", n_prog, 43);
    chk(n_pfpage == 2, "T4 R6 retry on lower half", n_pfpage, 2);
    check_clean("T4");
    pf_addr = -1; pf_mode = 0;

    // T5: slot 1, byte that will not erase
    fill(-1);
    stuck_addr = SLB + 7 * CH + 5;
    fmem[stuck_addr] = 8'h5A;
    run(1, 128, 0);
    chk(err && !done, "T5 R3 erase failure flagged", {done, err}, 1);
    chk(err_addr == 16'(stuck_addr), "T5 R3 error address", err_addr, stuck_addr);
    chk(err_exp == 8'hFF && err_act == 8'h5A, "T5 R3 error bytes", {err_exp, err_act}, 16'hFF5A);
    chk(src_sent == 0 && n_prog == 0, "T5 R3 no programming after failure", n_prog, 0);
    check_clean("T5");
    stuck_addr = -1;

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule